// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is a countdown timer that slows a base tick through a programmable divider and counts a current-count register down towards zero. Software sets it up with three writable registers: an initial count, a divide configuration and a timer control word. The control word holds the interrupt vector, a mask bit and the mode select. Writing the initial count arms the timer. A nonzero value starts a fresh count, and zero stops the timer.

When the count expires, the timer raises a request strobe and presents the configured vector with it, unless the request is masked. In one-shot mode the timer then stops with the count at zero. In periodic mode it reloads from the initial count and keeps running. The interrupt controller that takes the strobe is a separate block.

All four registers are read back on dedicated output ports, so the live count can be observed at any time.

Top module: `cdt_timer`

## Requirements
- R1: After reset the current count, initial count and divide configuration read 0. The control word reads 0x00010000 (masked, one-shot, vector 0). The timer is inactive and no request is raised.
- R2: The divide register keeps only data bits 3, 1 and 0. Its readback equals the written data AND 0xB.
- R3: The divide code is formed as {bit3, bit1, bit0}. Code 7 gives a divisor of 1, and any other code n gives a divisor of 2<<n (2 to 128). While the timer is active, the current count drops by one every divisor base ticks, and it holds while the tick input is low.
- R4: A write of a nonzero initial count (select 0) loads the current count on the next edge, marks the timer active and restarts the divider phase, abandoning any count in progress.
- R5: A write of zero to the initial count stops the timer with current count 0, and no request follows.
- R6: In one-shot mode (control bit 17 clear), the divided tick that finds the count at 1 sets the count to 0 and makes the timer inactive. In the same edge it raises the request for one cycle, with irq_vector_o equal to control bits 7:0.
- R7: In periodic mode (control bit 17 set), each expiry reloads the current count from the initial count, counting continues, and a request is raised on every expiry.
- R8: While control bit 16 (mask) is set, expiries raise no request, but counting and stopping proceed as normal.
- R9: The control word (select 2) keeps only bits 17, 16 and 7:0. A write made while sw_enable_i is low forces bit 16 to 1.
- R10: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick enable, one count step of the divider per high cycle |
| sw_enable_i | input | 1 | Controller software enable; low forces the mask on control writes |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 initial count, 1 divide, 2 control, 3 none |
| wr_data_i | input | 32 | Write data |
| init_count_o | output | 32 | Initial count readback |
| cur_count_o | output | 32 | Live current count |
| div_cfg_o | output | 32 | Divide configuration readback |
| timer_ctrl_o | output | 32 | Control word readback |
| active_o | output | 1 | Timer is counting |
| irq_o | output | 1 | Edge request strobe, one cycle per unmasked expiry |
| irq_vector_o | output | 8 | Vector of the latest expiry |

## Verification
A wrong divider phase or divisor decode shows up on cur_count_o at the first divided tick, one edge off the expected step. It also moves the irq_o pulse by whole multiples of the divisor. A stale active flag or a missed reload becomes visible at the first expiry: cur_count_o shows 0 where the reloaded value is expected, or irq_o stays low where later periodic pulses are due. A corrupted control word shows on timer_ctrl_o one cycle after the write, and a wrong mask or vector shows on the next expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int REG_W        = 32;
   localparam int VEC_W        = 8;
   localparam int CTRL_PER_BIT = 17;
   localparam int CTRL_MSK_BIT = 16;

   typedef enum logic [1:0] {
      SEL_INIT = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } cdt_sel_e;

   typedef struct packed {
      logic             periodic;
      logic             mask;
      logic [VEC_W-1:0] vector;
   } cdt_ctrl_t;
endpackage

// File: rtl/cdt_cfg_regs.sv
module cdt_cfg_regs
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_sel_i,
   input  logic [REG_W-1:0]     wr_data_i,
   input  logic                 sw_enable_i,
   output logic [2:0]           div_code_o,
   output cdt_ctrl_t            ctrl_o,
   output logic [CNT_W-1:0]     init_o,
   output logic                 init_wr_o
);
   cdt_sel_e sel;
   logic     wr_div, wr_ctrl;

   assign sel       = cdt_sel_e'(wr_sel_i);
   assign init_wr_o = wr_en_i && (sel == SEL_INIT);
   assign wr_div    = wr_en_i && (sel == SEL_DIV);
   assign wr_ctrl   = wr_en_i && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_code_o <= 3'd0;
         ctrl_o     <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
         init_o     <= '0;
      end else begin
         if (init_wr_o) init_o <= wr_data_i[CNT_W-1:0];
         // code bit 2 comes from data bit 3, bits 1:0 stay in place
         if (wr_div) div_code_o <= {wr_data_i[3], wr_data_i[1:0]};
         if (wr_ctrl) begin
            ctrl_o.periodic <= wr_data_i[CTRL_PER_BIT];
            ctrl_o.mask     <= wr_data_i[CTRL_MSK_BIT] | ~sw_enable_i;
            ctrl_o.vector   <= wr_data_i[VEC_W-1:0];
         end
      end
   end

   // R9: a control write while disabled always leaves the mask set
   p_ctrl_forced_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_ctrl && !sw_enable_i) |-> ctrl_o.mask);
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int  MAX_DIV_LOG2 = 7,
   parameter bit  TABLE_DECODE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       run_i,
   input  logic       restart_i,
   input  logic [2:0] div_code_i,
   output logic       dtick_o
);
   localparam int PRE_W = MAX_DIV_LOG2;

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] div_m1;

   generate
      if (MAX_DIV_LOG2 != 7) begin : g_bad_width
         $error("cdt_prescaler: the 3-bit code needs MAX_DIV_LOG2 of 7");
      end
      if (TABLE_DECODE) begin : g_table
         always_comb begin
            unique case (div_code_i)
               3'd0:    div_m1 = PRE_W'(1);
               3'd1:    div_m1 = PRE_W'(3);
               3'd2:    div_m1 = PRE_W'(7);
               3'd3:    div_m1 = PRE_W'(15);
               3'd4:    div_m1 = PRE_W'(31);
               3'd5:    div_m1 = PRE_W'(63);
               3'd6:    div_m1 = PRE_W'(127);
               default: div_m1 = '0;
            endcase
         end
      end else begin : g_shift
         logic [PRE_W:0] full;
         assign full   = (PRE_W+1)'(2) << div_code_i;
         assign div_m1 = (div_code_i == 3'd7) ? '0 : PRE_W'(full - 1'b1);
      end
   endgenerate

   assign dtick_o = run_i && tick_i && !restart_i && (pre_cnt >= div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (restart_i || !run_i) begin
         pre_cnt <= '0;
      end else if (tick_i) begin
         pre_cnt <= dtick_o ? '0 : pre_cnt + 1'b1;
      end
   end

   // R4: the divider phase is cleared whenever the timer was idle
   p_pre_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_i) |-> (pre_cnt == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_wr_i,
   input  logic [CNT_W-1:0] init_data_i,
   input  logic [CNT_W-1:0] init_val_i,
   input  logic             periodic_i,
   input  logic             dtick_i,
   output logic [CNT_W-1:0] cur_o,
   output logic             active_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("cdt_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   assign expire_o = active_o && dtick_i && !init_wr_i && (cur_o == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_o    <= '0;
         active_o <= 1'b0;
      end else if (init_wr_i) begin
         cur_o    <= init_data_i;
         active_o <= |init_data_i;
      end else if (active_o && dtick_i) begin
         if (cur_o == ONE) begin
            cur_o    <= periodic_i ? init_val_i : '0;
            active_o <= periodic_i;
         end else begin
            cur_o <= cur_o - 1'b1;
         end
      end
   end

   // R4: a running timer never shows a zero count
   p_active_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (cur_o != '0));
   // R6: stopping without a restart leaves the count at zero
   p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(active_o) && !$past(init_wr_i)) |-> (cur_o == '0));
   // R3: while running, the count moves by one step or by a reload only
   p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active_o) && active_o && !$past(init_wr_i) && (cur_o != $past(cur_o)))
      |-> ((cur_o == $past(cur_o) - 1'b1) || (cur_o == init_val_i)));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter bit TABLE_DECODE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             sw_enable_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [31:0]      wr_data_i,
   output logic [31:0]      init_count_o,
   output logic [31:0]      cur_count_o,
   output logic [31:0]      div_cfg_o,
   output logic [31:0]      timer_ctrl_o,
   output logic             active_o,
   output logic             irq_o,
   output logic [7:0]       irq_vector_o
);
   localparam int MAX_DIV_LOG2 = 7;

   logic [2:0]       div_code;
   cdt_ctrl_t        ctrl;
   logic [CNT_W-1:0] init_val;
   logic             init_wr;
   logic             dtick;
   logic [CNT_W-1:0] cur;
   logic             active;
   logic             expire;

   cdt_cfg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .sw_enable_i(sw_enable_i),
      .div_code_o (div_code),
      .ctrl_o     (ctrl),
      .init_o     (init_val),
      .init_wr_o  (init_wr)
   );

   cdt_prescaler #(.MAX_DIV_LOG2(MAX_DIV_LOG2), .TABLE_DECODE(TABLE_DECODE)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .run_i     (active),
      .restart_i (init_wr),
      .div_code_i(div_code),
      .dtick_o   (dtick)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_wr_i  (init_wr),
      .init_data_i(wr_data_i[CNT_W-1:0]),
      .init_val_i (init_val),
      .periodic_i (ctrl.periodic),
      .dtick_i    (dtick),
      .cur_o      (cur),
      .active_o   (active),
      .expire_o   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o        <= 1'b0;
         irq_vector_o <= '0;
      end else begin
         irq_o <= expire && !ctrl.mask;
         if (expire) irq_vector_o <= ctrl.vector;
      end
   end

   always_comb begin
      timer_ctrl_o               = '0;
      timer_ctrl_o[CTRL_PER_BIT] = ctrl.periodic;
      timer_ctrl_o[CTRL_MSK_BIT] = ctrl.mask;
      timer_ctrl_o[VEC_W-1:0]    = ctrl.vector;
   end

   assign div_cfg_o    = {28'd0, div_code[2], 1'b0, div_code[1:0]};
   assign init_count_o = 32'(init_val);
   assign cur_count_o  = 32'(cur);
   assign active_o     = active;

   // R8: a request only follows an expiry seen with the mask clear
   p_req_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(ctrl.mask));
endmodule

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        sw_enable_i = 1'b1;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = 2'd3;
   logic [31:0] wr_data_i = '0;
   logic [31:0] init_count_o, cur_count_o, div_cfg_o, timer_ctrl_o;
   logic        active_o, irq_o;
   logic [7:0]  irq_vector_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   cdt_timer i_cdt_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sw_enable_i(sw_enable_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .init_count_o(init_count_o), .cur_count_o(cur_count_o),
      .div_cfg_o(div_cfg_o), .timer_ctrl_o(timer_ctrl_o),
      .active_o(active_o), .irq_o(irq_o), .irq_vector_o(irq_vector_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog all requirements: actual %0d cycles expected < 100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0; wr_sel_i = 2'd3;
   endtask

   task automatic t_reset();
      chk("R1", "cur", cur_count_o, 32'h0);
      chk("R1", "init", init_count_o, 32'h0);
      chk("R1", "div", div_cfg_o, 32'h0);
      chk("R1", "ctrl", timer_ctrl_o, 32'h0001_0000);
      chk("R1", "active", 32'(active_o), 32'h0);
      chk("R1", "irq", 32'(irq_o), 32'h0);
   endtask

   task automatic t_div_bits();
      wr(2'd1, 32'hFFFF_FFFF);
      chk("R2", "div all ones", div_cfg_o, 32'hB);
      wr(2'd1, 32'h0000_0004);
      chk("R2", "div bit2 only", div_cfg_o, 32'h0);
   endtask

   task automatic t_ctrl_bits();
      sw_enable_i = 1'b1;
      wr(2'd2, 32'hFFFF_FFFF);
      chk("R9", "ctrl all ones", timer_ctrl_o, 32'h0003_00FF);
      sw_enable_i = 1'b0;
      wr(2'd2, 32'h0002_0030);
      chk("R9", "ctrl forced mask", timer_ctrl_o, 32'h0003_0030);
      sw_enable_i = 1'b1;
   endtask

   task automatic t_sel_none();
      logic [31:0] i0, d0, c0;
      i0 = init_count_o; d0 = div_cfg_o; c0 = timer_ctrl_o;
      wr(2'd3, 32'h1234_5678);
      chk("R10", "init kept", init_count_o, i0);
      chk("R10", "div kept", div_cfg_o, d0);
      chk("R10", "ctrl kept", timer_ctrl_o, c0);
      chk("R10", "still idle", 32'(active_o), 32'h0);
   endtask

   task automatic t_oneshot();
      tick_i = 1'b1;
      wr(2'd2, 32'h0000_0041);
      wr(2'd1, 32'h0);           // divide by 2
      wr(2'd0, 32'd3);
      chk("R4", "loaded", cur_count_o, 32'd3);
      chk("R4", "active", 32'(active_o), 32'h1);
      repeat (2) @(negedge clk);
      chk("R3", "after 2 ticks", cur_count_o, 32'd2);
      repeat (3) @(negedge clk);
      chk("R6", "no early irq", 32'(irq_o), 32'h0);
      @(negedge clk);
      chk("R6", "irq at expiry", 32'(irq_o), 32'h1);
      chk("R6", "vector", 32'(irq_vector_o), 32'h41);
      chk("R6", "count zero", cur_count_o, 32'h0);
      chk("R6", "inactive", 32'(active_o), 32'h0);
      @(negedge clk);
      chk("R6", "pulse ends", 32'(irq_o), 32'h0);
   endtask

   task automatic t_divisor(input logic [31:0] divreg, input int divisor);
      int e = 0;
      bit seen = 0;
      tick_i = 1'b1;
      wr(2'd2, 32'h0000_0022);
      wr(2'd1, divreg);
      wr(2'd0, 32'd2);
      while (!seen && e < 400) begin
         @(negedge clk);
         e++;
         seen = irq_o;
      end
      chk("R3", $sformatf("edges to expiry, div %0d", divisor), 32'(e), 32'(2 * divisor));
   endtask

   task automatic t_periodic();
      int n = 0;
      tick_i = 1'b1;
      wr(2'd2, 32'h0002_0055);
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd3);
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         if (irq_o) n++;
         if (k == 3) begin
            chk("R7", "reloaded", cur_count_o, 32'd3);
            chk("R7", "still active", 32'(active_o), 32'h1);
         end
      end
      chk("R7", "request count", 32'(n), 32'd3);
      chk("R7", "vector", 32'(irq_vector_o), 32'h55);
      wr(2'd0, 32'd0);
   endtask

   task automatic t_masked();
      int n = 0;
      tick_i = 1'b1;
      wr(2'd2, 32'h0001_0020);
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd2);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (irq_o) n++;
      end
      chk("R8", "no request", 32'(n), 32'd0);
      chk("R8", "stopped", 32'(active_o), 32'h0);
      chk("R8", "count zero", cur_count_o, 32'h0);
   endtask

   task automatic t_restart();
      int n = 0;
      tick_i = 1'b1;
      wr(2'd2, 32'h0000_0000);
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd5);
      repeat (3) @(negedge clk);
      chk("R3", "count 2", cur_count_o, 32'd2);
      wr(2'd0, 32'd5);
      chk("R4", "restart reload", cur_count_o, 32'd5);
      wr(2'd0, 32'd0);
      chk("R5", "zero count", cur_count_o, 32'h0);
      chk("R5", "inactive", 32'(active_o), 32'h0);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (irq_o) n++;
      end
      chk("R5", "no request", 32'(n), 32'd0);
   endtask

   task automatic t_tick_gate();
      tick_i = 1'b0;
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd4);
      repeat (10) @(negedge clk);
      chk("R3", "holds without tick", cur_count_o, 32'd4);
      tick_i = 1'b1;
      @(negedge clk);
      chk("R3", "one tick step", cur_count_o, 32'd3);
      wr(2'd0, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div_bits();
      t_ctrl_bits();
      t_sel_none();
      t_oneshot();
      t_divisor(32'hB, 1);
      t_divisor(32'h3, 16);
      t_divisor(32'h8, 32);
      t_divisor(32'hA, 128);
      t_periodic();
      t_masked();
      t_restart();
      t_tick_gate();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule